// File: doc/BRIEF.md
# Recursive Zadoff–Chu Phase Index Generator

This block walks through the elements of a prime-length Zadoff–Chu root and presents, for each element, its integer phase index in the range 0 to N−1. The actual phase angle is 2π times that index divided by N, and a downstream rotator turns it into a complex sample. The quadratic phase γ·k(k+1)/2 mod N, with k = m·n, is built from two chained first-order accumulators. Each accumulator is reduced modulo N with one comparison and at most one subtraction, so the block has no multiplier and no divider.

Two constants select the mode. The first is `step`, equal to γ·m² mod N. The second is `beta0`, equal to −γ·m(m−1)/2 mod N. Both are computed elsewhere.

- With m = 1 the output is the time-domain phase sequence.
- With m equal to the modular inverse of γ, the output is the phase of the conjugated element at position m·n. This gives the frequency-domain sequence in reordered form, up to a constant factor.

A `start` pulse restarts the recursion. The consumer then pulls one element per cycle in which `advance` is high. Each element comes with `valid`, its index and a `last` flag.

Top module: `zc_phase_gen`

## Requirements
- R1: After reset `valid` and `last` are low.
- R2: In the cycle after `start` is high, `valid` is 1, `index` is 0 and `phase` is 0, whatever state the block was in before.
- R3: With `step` = γ mod N and `beta0` = 0 (time domain), the element at index n carries `phase` = γ·n(n+1)/2 mod N, for every n from 0 to N−1.
- R4: With `step` = γ·m² mod N and `beta0` = (N − γ·(m(m−1)/2) mod N) mod N, where m is the modular inverse of γ, the element at index n carries `phase` = γ·k(k+1)/2 mod N, where k = m·n. This is the frequency-domain order.
- R5: While `valid` is high, `phase` is below `n_len`.
- R6: A cycle with `valid` high and `advance` low leaves `phase`, `index` and `valid` unchanged. A cycle with `advance` high and `last` low moves to index + 1.
- R7: `last` is high exactly when `valid` is high and `index` is N−1. When the last element is accepted, `valid` falls in the next cycle.
- R8: A `start` in the middle of a run abandons that run and restarts from index 0.
- R9: A `start` in the cycle right after the last element is accepted begins a new full sequence with no gap beyond that one cycle. The required lengths are N = 139 and N = 839.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart the sequence at index 0 |
| advance | input | 1 | Accept the current element and step to the next |
| n_len | input | W | Sequence length N (odd prime) |
| step | input | W | γ·m² mod N |
| beta0 | input | W | Initial β value, −γ·m(m−1)/2 mod N |
| phase | output | W | Phase index of the current element |
| index | output | W | Element index n |
| valid | output | 1 | An element is being presented |
| last | output | 1 | The current element is index N−1 |

## Verification
The embedded assertions check the control behaviour on every cycle:
- the phase stays below N;
- the element holds during a stall;
- the index moves by one on each accepted step;
- a start yields index 0 with phase 0;
- the sequence ends after the last element is accepted.

The correctness of the phase values themselves can only be shown by the bench. It compares every element against direct evaluation of the quadratic, for several roots, both lengths and both domain modes, with stalls, an aborted run and back-to-back restarts.

// File: rtl/zc_phase_gen.sv
module zc_phase_gen #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         advance,
  input  logic [W-1:0] n_len,
  input  logic [W-1:0] step,
  input  logic [W-1:0] beta0,
  output logic [W-1:0] phase,
  output logic [W-1:0] index,
  output logic         valid,
  output logic         last
);
  localparam int WX = W + 1;

  logic         active;
  logic [W-1:0] cnt, alpha, beta;

  logic [WX-1:0] nx, b_sum, b_red, a_sum, a_red;
  logic [W-1:0]  b_nx, a_nx;
  logic          at_end;

  assign nx    = {1'b0, n_len};
  assign b_sum = {1'b0, beta} + {1'b0, step};
  assign b_red = b_sum - nx;
  assign b_nx  = (b_sum >= nx) ? b_red[W-1:0] : b_sum[W-1:0];
  assign a_sum = {1'b0, alpha} + {1'b0, b_nx};
  assign a_red = a_sum - nx;
  assign a_nx  = (a_sum >= nx) ? a_red[W-1:0] : a_sum[W-1:0];

  assign at_end = (cnt == n_len - 1'b1);
  assign phase  = alpha;
  assign index  = cnt;
  assign valid  = active;
  assign last   = active & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      alpha  <= '0;
      beta   <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      alpha  <= '0;
      beta   <= beta0;
    end else if (active && advance) begin
      if (at_end) begin
        active <= 1'b0;
      end else begin
        cnt   <= cnt + 1'b1;
        beta  <= b_nx;
        alpha <= a_nx;
      end
    end
  end

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (phase < n_len));

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (valid && index == '0 && phase == '0));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !advance && !start) |=> (valid && $stable(phase) && $stable(index)));

  // R6
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && advance && !last && !start) |=> (valid && index == $past(index) + 1'b1));

  // R7
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && advance && !start) |=> !valid);
endmodule

// File: tb/tb_zc_phase_gen.sv
module tb_zc_phase_gen;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         advance = 1'b0;
  logic [W-1:0] n_len = '0;
  logic [W-1:0] step = '0;
  logic [W-1:0] beta0 = '0;
  logic [W-1:0] phase, index;
  logic         valid, last;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  zc_phase_gen #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .n_len(n_len), .step(step), .beta0(beta0),
    .phase(phase), .index(index), .valid(valid), .last(last)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint inv_mod(input longint g, input longint n);
    for (longint x = 1; x < n; x++) if ((g * x) % n == 1) return x;
    return 0;
  endfunction

  function automatic longint zc_phase(input longint g, input longint m,
                                      input longint n, input longint i);
    longint k = m * i;
    return (g * ((k * (k + 1) / 2) % n)) % n;
  endfunction

  task automatic setup(input longint n, input longint g, input longint m);
    n_len = W'(n);
    step  = W'((g * ((m * m) % n)) % n);
    beta0 = W'((n - (g * ((m * (m - 1) / 2) % n)) % n) % n);
  endtask

  task automatic run_seq(input string req, input longint n, input longint g,
                         input longint m, input int stall_every, input int abort_at);
    start = 1'b1; advance = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check({req, "/R2 valid"}, valid, 1);
    check("R2 index", index, 0);
    check("R2 phase", phase, 0);
    for (longint i = 0; i < n; i++) begin
      if (abort_at > 0 && i == abort_at) return;
      check({req, " phase"}, phase, zc_phase(g, m, n, i));
      check("R6 index", index, i);
      check("R7 last", last, (i == n - 1) ? 1 : 0);
      if (stall_every > 0 && (i % stall_every) == 2) begin
        advance = 1'b0;
        @(negedge clk);
        check("R6 stall valid", valid, 1);
        check("R6 stall phase", phase, zc_phase(g, m, n, i));
        check("R6 stall index", index, i);
      end
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
    end
    check("R7 valid after last", valid, 0);
    check("R7 last after end", last, 0);
  endtask

  initial begin
    #5;
    check("R1 valid", valid, 0);
    check("R1 last", last, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid held", valid, 0);

    begin
      longint lens[2] = '{139, 839};
      longint roots[3] = '{1, 25, 129};
      foreach (lens[li]) begin
        foreach (roots[ri]) begin
          longint g = roots[ri] % lens[li];
          setup(lens[li], g, 1);
          run_seq("R3", lens[li], g, 1, (ri == 1) ? 7 : 0, 0);
          setup(lens[li], g, inv_mod(g, lens[li]));
          run_seq("R4/R9", lens[li], g, inv_mod(g, lens[li]), (ri == 2) ? 5 : 0, 0);
        end
      end
    end

    setup(139, 17, 1);
    run_seq("R8 pre", 139, 17, 1, 0, 60);
    setup(139, 17, inv_mod(17, 139));
    run_seq("R8", 139, 17, inv_mod(17, 139), 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule